// File: doc/BRIEF.md
# I2C register-pair GPIO port controller

This block is a serial-bus slave that controls a 16-pin general-purpose I/O port made of two 8-bit ports. A bus master reaches it through eight byte-wide registers, grouped into four pairs of two. One pair returns the pin levels. One pair holds the values driven onto the pins. One pair inverts the read polarity of individual input bits. One pair chooses each pin's direction. Each of SCL and SDA passes through a plain flop synchronizer clocked by the system clock, which oversamples the bus. The block finds bus conditions from the synchronized samples. It drives SDA only through a pull-down enable. Three strap pins choose one of eight bus addresses, so eight of these blocks can share one bus.

A write transaction sends the address byte with the direction bit clear, then a command byte that sets a 3-bit register pointer, then any number of data bytes. A read transaction first writes the command byte, then issues a repeated START and the address byte with the direction bit set. The slave then returns bytes until the master declines to acknowledge one. After every data byte the pointer moves to the other register of its pair. A burst therefore alternates between port 1 and port 0 and does not advance to the next pair.

The protocol engine is a state machine with these states:
- `ST_IDLE`: waits for a START.
- `ST_ADDR`: shifts in the address byte.
- `ST_ADDR_ACK`: pulls SDA low during the ninth clock.
- `ST_CMD`: receives the command byte.
- `ST_CMD_ACK`: acknowledges the command byte.
- `ST_WDATA`: receives a data byte.
- `ST_WDATA_ACK`: acknowledges a data byte.
- `ST_RDATA`: shifts read data out, MSB first.
- `ST_RD_ACK`: samples the master's acknowledge.
- `ST_WAIT`: keeps SDA released until the next bus condition.

The transitions are:
- A START moves every state to `ST_ADDR`.
- A STOP moves every state to `ST_IDLE`.
- `ST_ADDR` moves to `ST_ADDR_ACK` on an address match after the eighth bit, and to `ST_WAIT` otherwise.
- `ST_ADDR_ACK` moves to `ST_RDATA` for a read and to `ST_CMD` for a write.
- `ST_CMD` moves to `ST_CMD_ACK`, and `ST_CMD_ACK` moves to `ST_WDATA`.
- `ST_WDATA` and `ST_WDATA_ACK` alternate.
- `ST_RDATA` moves to `ST_RD_ACK`.
- `ST_RD_ACK` moves back to `ST_RDATA` when the master acknowledges, and to `ST_WAIT` when it does not.

Top module: `gpio_i2c_expander`

## Requirements
- R1: A START (SDA falls while SCL is high) begins address reception in any state, even in the middle of a byte. A STOP (SDA rises while SCL is high) returns the block to idle. In idle, clocked bytes are not acknowledged.
- R2: The 7-bit address is 4'b0100 followed by addr_sel[2:0]. Bit 0 of the address byte is 0 for a write and 1 for a read. On a match the slave pulls SDA low for the ninth clock. On a mismatch it does not acknowledge, and it ignores all traffic until the next START or STOP.
- R3: Bits [2:0] of the command byte load the pointer. Codes 0 and 1 select input ports 0 and 1. Codes 2 and 3 select output ports 0 and 1. Codes 4 and 5 select polarity ports 0 and 1. Codes 6 and 7 select direction ports 0 and 1. Every command byte is acknowledged.
- R4: After each data byte, written or read, pointer bit 0 inverts while bits [2:1] stay. Bursts have no length limit.
- R5: Writes to codes 0 and 1 change nothing, and pin_out and pin_oe keep their values.
- R6: Reading input port p returns pin_in[8p+7:8p] XOR polarity port p. The pin level is returned whatever direction the pin has.
- R7: Reading an output port returns the stored byte, not the pin level. pin_out[8p+i] equals output port p bit i. pin_oe[8p+i] equals the inverse of direction port p bit i.
- R8: After reset both output ports hold 8'hFF, both polarity ports hold 8'h00, both direction ports hold 8'hFF (pin_oe all 0), and the pointer is 0.
- R9: Read data goes out MSB first. It is loaded on the SCL falling edge that ends the preceding acknowledge. When the master acknowledges, the next byte follows. When the master does not acknowledge, the slave releases SDA until the next START or STOP.
- R10: The slave changes its SDA drive only after an SCL falling edge or a bus condition, never while SCL stays high with SDA steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| addr_sel | input | 3 | Strap pins forming the low three address bits |
| pin_in | input | 16 | Pin levels; bits 7:0 are port 0, bits 15:8 are port 1 |
| sda_pull | output | 1 | 1 pulls SDA low |
| pin_out | output | 16 | Value driven on each pin whose driver is enabled |
| pin_oe | output | 16 | Per-pin driver enable, 1 drives |

## Verification
The register-pair access path is tried with bursts that start at port 1 and bursts that start at port 0. These bursts separate the pair toggle from a linear increment, and a four-byte write followed by a three-byte read shows the wrap inside the pair. Input reads use pin patterns with different upper and lower halves and unequal polarity masks. The patterns show that the XOR applies per port and per bit, and that the pins are sampled whatever their direction. Other directed cases cover these conditions: a wrong address, a START in the middle of a byte, bytes clocked after a STOP, and the master's final refusal to acknowledge. Each of these cases separates correct framing from an engine that keeps listening or keeps driving.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    localparam int BYTE_W    = 8;
    localparam int NUM_PORTS = 2;
    localparam int PIN_W     = BYTE_W * NUM_PORTS;
    localparam int IDX_W     = 3;

    // Register kind is carried in pointer bits [2:1]; bit 0 picks the port.
    localparam logic [1:0] KIND_IN  = 2'd0;
    localparam logic [1:0] KIND_OUT = 2'd1;
    localparam logic [1:0] KIND_POL = 2'd2;
    localparam logic [1:0] KIND_CFG = 2'd3;

    localparam logic [BYTE_W-1:0] OUT_RST = 8'hFF;
    localparam logic [BYTE_W-1:0] POL_RST = 8'h00;
    localparam logic [BYTE_W-1:0] CFG_RST = 8'hFF;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RD_ACK,
        ST_WAIT
    } gpx_state_e;

endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
    import gpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [PIN_W-1:0]  pins_s,
    output logic [BYTE_W-1:0] rd_data,
    output logic [PIN_W-1:0]  out_q,
    output logic [PIN_W-1:0]  cfg_q
);

    logic [PIN_W-1:0] pol_q;

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            logic              sel;
            logic [BYTE_W-1:0] out_r;
            logic [BYTE_W-1:0] pol_r;
            logic [BYTE_W-1:0] cfg_r;

            assign sel = wr_en && (wr_idx[0] == 1'(p));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    out_r <= OUT_RST;
                    pol_r <= POL_RST;
                    cfg_r <= CFG_RST;
                end else if (sel) begin
                    case (wr_idx[IDX_W-1:1])
                        KIND_OUT: out_r <= wr_data;
                        KIND_POL: pol_r <= wr_data;
                        KIND_CFG: cfg_r <= wr_data;
                        default:  ; // input ports are read-only
                    endcase
                end
            end

            assign out_q[p*BYTE_W +: BYTE_W] = out_r;
            assign pol_q[p*BYTE_W +: BYTE_W] = pol_r;
            assign cfg_q[p*BYTE_W +: BYTE_W] = cfg_r;
        end
    endgenerate

    logic [$clog2(PIN_W)-1:0] base;
    assign base = {rd_idx[0], 3'b000};

    always_comb begin
        unique case (rd_idx[IDX_W-1:1])
            KIND_IN:  rd_data = pins_s[base +: BYTE_W] ^ pol_q[base +: BYTE_W];
            KIND_OUT: rd_data = out_q[base +: BYTE_W];
            KIND_POL: rd_data = pol_q[base +: BYTE_W];
            KIND_CFG: rd_data = cfg_q[base +: BYTE_W];
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/gpx_bus_fsm.sv
module gpx_bus_fsm
    import gpx_pkg::*;
#(
    parameter logic [3:0] ADDR_FIXED = 4'b0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic [2:0]        addr_sel,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_pull,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic [IDX_W-1:0]  rd_idx,
    output gpx_state_e        state_o
);

    localparam int               CNT_W    = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    gpx_state_e        state, state_nx;
    logic              scl_q, sda_q;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  bitcnt;
    logic              rw_q;
    logic              mack_q;
    logic [IDX_W-1:0]  ptr;

    logic start_ev, stop_ev, rise_ev, fall_ev, byte_done, addr_hit;

    // Bus condition detection on the synchronized samples
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign start_ev  = scl_s && scl_q && sda_q && !sda_s;
    assign stop_ev   = scl_s && scl_q && !sda_q && sda_s;
    assign rise_ev   = scl_s && !scl_q;
    assign fall_ev   = !scl_s && scl_q;
    assign byte_done = fall_ev && (bitcnt == LAST_BIT);
    assign addr_hit  = (shreg[BYTE_W-1:1] == {ADDR_FIXED, addr_sel});

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (start_ev) begin
            state_nx = ST_ADDR;
        end else if (stop_ev) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      state_nx = ST_IDLE;
                ST_ADDR:      if (byte_done) state_nx = addr_hit ? ST_ADDR_ACK : ST_WAIT;
                ST_ADDR_ACK:  if (fall_ev)   state_nx = rw_q ? ST_RDATA : ST_CMD;
                ST_CMD:       if (byte_done) state_nx = ST_CMD_ACK;
                ST_CMD_ACK:   if (fall_ev)   state_nx = ST_WDATA;
                ST_WDATA:     if (byte_done) state_nx = ST_WDATA_ACK;
                ST_WDATA_ACK: if (fall_ev)   state_nx = ST_WDATA;
                ST_RDATA:     if (byte_done) state_nx = ST_RD_ACK;
                ST_RD_ACK:    if (fall_ev)   state_nx = mack_q ? ST_RDATA : ST_WAIT;
                ST_WAIT:      state_nx = ST_WAIT;
                default:      state_nx = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Shift register, bit counter and register pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg  <= '0;
            bitcnt <= '0;
            rw_q   <= 1'b0;
            mack_q <= 1'b0;
            ptr    <= '0;
        end else if (start_ev) begin
            bitcnt <= '0;
        end else begin
            case (state)
                ST_ADDR, ST_CMD, ST_WDATA: begin
                    if (rise_ev) begin
                        shreg  <= {shreg[BYTE_W-2:0], sda_s};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (byte_done) begin
                        bitcnt <= '0;
                        if (state == ST_ADDR)  rw_q <= shreg[0];
                        if (state == ST_CMD)   ptr  <= shreg[IDX_W-1:0];
                        if (state == ST_WDATA) ptr  <= {ptr[IDX_W-1:1], ~ptr[0]};
                    end
                end
                ST_ADDR_ACK: begin
                    if (fall_ev && rw_q) shreg <= rd_data;
                end
                ST_RDATA: begin
                    if (rise_ev) begin
                        bitcnt <= bitcnt + 1'b1;
                    end else if (byte_done) begin
                        bitcnt <= '0;
                        ptr    <= {ptr[IDX_W-1:1], ~ptr[0]};
                    end else if (fall_ev) begin
                        shreg <= {shreg[BYTE_W-2:0], 1'b0};
                    end
                end
                ST_RD_ACK: begin
                    if (rise_ev)                mack_q <= ~sda_s;
                    else if (fall_ev && mack_q) shreg  <= rd_data;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        wr_en   = (state == ST_WDATA) && byte_done;
        wr_idx  = ptr;
        wr_data = shreg;
        rd_idx  = ptr;
        state_o = state;
        unique case (state)
            ST_ADDR_ACK, ST_CMD_ACK, ST_WDATA_ACK: sda_pull = 1'b1;
            ST_RDATA:                              sda_pull = ~shreg[BYTE_W-1];
            default:                               sda_pull = 1'b0;
        endcase
    end

endmodule

// File: rtl/gpio_i2c_expander.sv
module gpio_i2c_expander
    import gpx_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] ADDR_FIXED  = 4'b0100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_in,
    input  logic        sda_in,
    input  logic [2:0]  addr_sel,
    input  logic [15:0] pin_in,
    output logic        sda_pull,
    output logic [15:0] pin_out,
    output logic [15:0] pin_oe
);

    logic              scl_s, sda_s;
    logic [PIN_W-1:0]  pins_s;
    logic [BYTE_W-1:0] rd_data, wr_data;
    logic [IDX_W-1:0]  wr_idx, rd_idx;
    logic              wr_en;
    logic [PIN_W-1:0]  out_q, cfg_q;
    gpx_state_e        fsm_state;

    gpx_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync_bus (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_in, sda_in}),
        .q     ({scl_s, sda_s})
    );

    gpx_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_pins (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pins_s)
    );

    gpx_bus_fsm #(.ADDR_FIXED(ADDR_FIXED)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .addr_sel (addr_sel),
        .rd_data  (rd_data),
        .sda_pull (sda_pull),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (rd_idx),
        .state_o  (fsm_state)
    );

    gpx_regfile u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .pins_s  (pins_s),
        .rd_data (rd_data),
        .out_q   (out_q),
        .cfg_q   (cfg_q)
    );

    assign pin_out = out_q;
    assign pin_oe  = ~cfg_q;

endmodule

// File: rtl/gpx_checker.sv
module gpx_checker
    import gpx_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             scl_s,
    input logic             sda_s,
    input logic             sda_pull,
    input logic [PIN_W-1:0] pin_out,
    input logic [PIN_W-1:0] pin_oe,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic [IDX_W-1:0] rd_idx,
    input gpx_state_e       fsm_state
);

    AST_SDA_MOVES_AFTER_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(scl_s) && $past(scl_s, 2) && ($past(sda_s) == $past(sda_s, 2))) |-> $stable(sda_pull))
        else $error("slave SDA drive changed while SCL high"); // R10

    AST_PAIR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_idx == {$past(rd_idx[IDX_W-1:1]), ~$past(rd_idx[0])}))
        else $error("pointer left its register pair"); // R4

    AST_INPUT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx[IDX_W-1:1] == KIND_IN)) |=> ($stable(pin_out) && $stable(pin_oe)))
        else $error("write to input port changed the pins"); // R5

    AST_PINS_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> ($stable(pin_oe) && $stable(pin_out)))
        else $error("pin controls changed without a write"); // R7

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(scl_s) && scl_s && !$past(sda_s) && sda_s) |=> (fsm_state == ST_IDLE))
        else $error("STOP did not return to idle"); // R1

endmodule

bind gpio_i2c_expander gpx_checker u_gpx_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .sda_pull  (sda_pull),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .rd_idx    (rd_idx),
    .fsm_state (fsm_state)
);

// File: tb/gpio_i2c_expander_bench.sv
`timescale 1ns/1ps
module gpio_i2c_expander_bench;

    typedef struct packed {
        logic [7:0]  cmd;
        logic [7:0]  d0;
        logic [7:0]  d1;
        logic [15:0] pins;
        logic [7:0]  e0;
        logic [7:0]  e1;
        logic [15:0] eout;
        logic [15:0] eoe;
    } vec_t;

    // write two bytes at cmd, then read two bytes back from cmd
    localparam vec_t VECS [5] = '{
        {8'h02, 8'hAA, 8'h55, 16'h0000, 8'hAA, 8'h55, 16'h55AA, 16'h0000}, // R7 stored output
        {8'h07, 8'h3C, 8'hC3, 16'h0000, 8'h3C, 8'hC3, 16'h55AA, 16'hC33C}, // R4 starts at port 1
        {8'h05, 8'h81, 8'h18, 16'h0000, 8'h81, 8'h18, 16'h55AA, 16'hC33C}, // polarity
        {8'h00, 8'h12, 8'h34, 16'hA5F0, 8'hE8, 8'h24, 16'h55AA, 16'hC33C}, // R5 R6
        {8'h01, 8'hFF, 8'hFF, 16'h0F0F, 8'h8E, 8'h17, 16'h55AA, 16'hC33C}  // R5 R6
    };

    localparam logic [7:0] ADDR_W = 8'h4A;
    localparam logic [7:0] ADDR_R = 8'h4B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [2:0]  addr_sel = 3'b101;
    logic [15:0] pin_in = 16'h00C3;
    logic        sda_bus;
    logic        sda_pull;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;
    logic [7:0]  rbuf [4];
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    assign sda_bus = sda_m & ~sda_pull;

    always #2.5 clk = ~clk;

    gpio_i2c_expander u_gpio_i2c_expander (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_m),
        .sda_in   (sda_bus),
        .addr_sel (addr_sel),
        .pin_in   (pin_in),
        .sda_pull (sda_pull),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

    task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic q(input int n = 1);
        repeat (8 * n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; q();
        scl_m = 1'b1; q();
        sda_m = 1'b0; q();
        scl_m = 1'b0; q();
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; q();
        scl_m = 1'b1; q();
        sda_m = 1'b1; q();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    q();
        scl_m = 1'b1; q(2);
        scl_m = 1'b0; q();
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; q();
        scl_m = 1'b1; q();
        b = sda_bus;  q();
        scl_m = 1'b0; q();
    endtask

    task automatic send_byte(input logic [7:0] d, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        acked = !b;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(!give_ack);
    endtask

    task automatic wr_tx(input logic [7:0] cmd, input int n,
                         input logic [7:0] d0, input logic [7:0] d1,
                         input logic [7:0] d2, input logic [7:0] d3);
        logic       a;
        logic [7:0] dd [4];
        dd[0] = d0; dd[1] = d1; dd[2] = d2; dd[3] = d3;
        bus_start;
        send_byte(ADDR_W, a); check("R2 write address ack", 16'(a), 16'd1);
        send_byte(cmd, a);    check("R3 command ack", 16'(a), 16'd1);
        for (int i = 0; i < n; i++) begin
            send_byte(dd[i], a); check("R4 data ack", 16'(a), 16'd1);
        end
        bus_stop;
    endtask

    task automatic rd_tx(input logic use_cmd, input logic [7:0] cmd, input int n);
        logic       a;
        logic [7:0] t;
        bus_start;
        if (use_cmd) begin
            send_byte(ADDR_W, a); check("R2 write address ack", 16'(a), 16'd1);
            send_byte(cmd, a);    check("R3 command ack", 16'(a), 16'd1);
            bus_start;
        end
        send_byte(ADDR_R, a); check("R2 read address ack", 16'(a), 16'd1);
        for (int i = 0; i < n; i++) begin
            recv_byte(t, i != n - 1);
            rbuf[i] = t;
        end
        q();
        check("R9 SDA released after final NACK", 16'(sda_pull), 16'd0);
        bus_stop;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R1 watchdog expired actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic a;
        repeat (4) @(negedge clk);
        check("R8 reset pin_oe", pin_oe, 16'h0000);
        check("R8 reset pin_out", pin_out, 16'hFFFF);
        check("R8 reset sda_pull", 16'(sda_pull), 16'd0);
        rst_n = 1'b1;
        q(2);

        // R8: pointer 0 after reset, read without a command byte
        rd_tx(1'b0, 8'h00, 2);
        check("R8 R6 first read hits input port 0", 16'(rbuf[0]), 16'h00C3);
        check("R4 second read hits input port 1", 16'(rbuf[1]), 16'h0000);
        rd_tx(1'b1, 8'h06, 2);
        check("R8 direction port 0 reset", 16'(rbuf[0]), 16'h00FF);
        check("R8 direction port 1 reset", 16'(rbuf[1]), 16'h00FF);
        rd_tx(1'b1, 8'h04, 2);
        check("R8 polarity port 0 reset", 16'(rbuf[0]), 16'h0000);
        check("R8 polarity port 1 reset", 16'(rbuf[1]), 16'h0000);

        // table walk
        for (int i = 0; i < 5; i++) begin
            vec_t v;
            v = VECS[i];
            pin_in = v.pins;
            wr_tx(v.cmd, 2, v.d0, v.d1, 8'h00, 8'h00);
            check("R7 pin_out after pair write", pin_out, v.eout);
            check("R7 pin_oe after pair write", pin_oe, v.eoe);
            rd_tx(1'b1, v.cmd, 2);
            check("R3 R6 first byte at command", 16'(rbuf[0]), 16'(v.e0));
            check("R4 R6 second byte from pair partner", 16'(rbuf[1]), 16'(v.e1));
        end

        // R4: long burst stays inside the output pair
        wr_tx(8'h03, 4, 8'h11, 8'h22, 8'h33, 8'h44);
        check("R4 burst write pin_out", pin_out, 16'h3344);
        rd_tx(1'b1, 8'h02, 3);
        check("R4 burst read byte 0", 16'(rbuf[0]), 16'h0044);
        check("R4 burst read byte 1", 16'(rbuf[1]), 16'h0033);
        check("R4 burst read byte 2", 16'(rbuf[2]), 16'h0044);

        // R2: wrong address is not acknowledged and writes nothing
        bus_start;
        send_byte(8'h40, a); check("R2 mismatched address NACK", 16'(a), 16'd0);
        send_byte(8'h02, a); check("R2 ignored after mismatch", 16'(a), 16'd0);
        send_byte(8'h00, a); check("R2 ignored data after mismatch", 16'(a), 16'd0);
        bus_stop;
        check("R2 pin_out unchanged after mismatch", pin_out, 16'h3344);

        // R1: START in the middle of a data byte restarts framing
        bus_start;
        send_byte(ADDR_W, a);
        send_byte(8'h02, a);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_start;
        send_byte(ADDR_W, a); check("R1 address ack after mid-byte START", 16'(a), 16'd1);
        send_byte(8'h02, a);  check("R1 command ack after mid-byte START", 16'(a), 16'd1);
        send_byte(8'h5A, a);  check("R1 data ack after mid-byte START", 16'(a), 16'd1);
        bus_stop;
        check("R1 pin_out after restarted write", pin_out, 16'h335A);

        // R1: bytes clocked after STOP without START are ignored
        send_byte(ADDR_W, a); check("R1 no ack while idle", 16'(a), 16'd0);
        bus_stop;
        check("R1 pin_out unchanged while idle", pin_out, 16'h335A);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule